// File: doc/BRIEF.md
# Storage Key Protection Unit

This unit guards memory accesses with per-frame storage keys. Every page frame owns a 4-bit key and a fetch-guard flag, kept in a small register table. Software sets them through a single write port. Each access names a frame, says whether it is a store or a fetch, and carries the 4-bit key field of the current program status word. An instruction may also supply an explicit key that stands in for the status-word key for that one access.

The unit selects the effective access key and compares it with the frame's stored key. It then grants or denies the access in the same cycle as the request. Key 0 acts as a master key. On a mismatch, a frame whose fetch-guard flag is clear still allows fetches but refuses stores. A frame whose flag is set refuses both. A denial raises a protection-exception strobe and reports the index of the offending frame. The exception handling path lies outside this unit.

Top module: `skey_guard`

## Requirements
- R1: After a synchronous reset every frame holds key 0 with the fetch-guard flag clear. A fetch with a nonzero access key is therefore granted and a store with a nonzero access key is denied.
- R2: The effective access key is `ovr_key` when `ovr_valid` is 1, and `psw_key` otherwise. While `ovr_valid` is 0, the value of `ovr_key` has no effect on any output.
- R3: An access whose effective key is 0 is granted for stores and fetches, whatever the frame's key and flag.
- R4: An access whose effective key equals the frame's stored key is granted for stores (`req_store`=1) and fetches (`req_store`=0).
- R5: On a key mismatch with a nonzero effective key and the frame's fetch-guard flag clear, a fetch is granted and a store is denied.
- R6: On a key mismatch with a nonzero effective key and the frame's fetch-guard flag set, both stores and fetches are denied.
- R7: While `deny` is 1, `exc_frame` equals `req_frame`. Otherwise `exc_frame` is 0.
- R8: While `req_valid` is 0, `grant` and `deny` are both 0.
- R9: When `cfg_we` is 1, the frame `cfg_frame` takes `cfg_key` and `cfg_fguard` at the clock edge. A request in the same cycle still sees the frame's previous contents.
- R10: `grant` and `deny` are never 1 together. The decision is combinational in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the key table |
| cfg_frame | input | IDX_W | Frame whose key and flag are written |
| cfg_key | input | 4 | Storage key to write |
| cfg_fguard | input | 1 | Fetch-guard flag to write |
| req_valid | input | 1 | Access request present |
| req_frame | input | IDX_W | Frame targeted by the access |
| req_store | input | 1 | 1 = store, 0 = fetch |
| psw_key | input | 4 | Key field of the current program status word |
| ovr_valid | input | 1 | Explicit instruction key in use |
| ovr_key | input | 4 | Explicit instruction key |
| grant | output | 1 | Access allowed |
| deny | output | 1 | Protection exception: access refused |
| exc_frame | output | IDX_W | Frame index of the refused access |

## Verification
The assertions keep a shadow copy of the key table. That copy assumes the write port is the only way keys and flags change, and that all inputs hold known values once reset is released. The stimulus meets both conditions. It drives every input to a defined value away from the clock edge, keeps frame indices inside the table, and changes keys only through `cfg_we`. In the random phase, writes and requests to the same frame are mixed freely. This exercises the rule that a same-cycle write is not yet visible to the request.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int SKEY_W = 4;

  typedef logic [SKEY_W-1:0] skey_t;

  typedef struct packed {
    skey_t key;
    logic  fguard;
  } frame_attr_t;

  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  localparam skey_t MASTER_KEY = '0;
endpackage

// File: rtl/skey_table.sv
module skey_table
  import skey_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  frame_attr_t wr_attr,
  input  logic [IDX_W-1:0] rd_idx,
  output frame_attr_t rd_attr
);
  localparam int DEPTH = 1 << IDX_W;

  frame_attr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_attr;
    end
  end

  assign rd_attr = mem[rd_idx];
endmodule

// File: rtl/skey_select.sv
module skey_select
  import skey_pkg::*;
(
  input  skey_t psw_key,
  input  logic  ovr_valid,
  input  skey_t ovr_key,
  output skey_t eff_key
);
  always_comb begin
    if (ovr_valid) eff_key = ovr_key;
    else           eff_key = psw_key;
  end
endmodule

// File: rtl/skey_judge.sv
module skey_judge
  import skey_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [IDX_W-1:0] req_frame,
  input  skey_t       eff_key,
  input  frame_attr_t attr,
  output logic        grant,
  output logic        deny,
  output logic [IDX_W-1:0] exc_frame
);
  logic      key_ok;
  logic      allowed;
  acc_kind_e kind;

  assign kind = acc_kind_e'(req_store);

  always_comb begin
    key_ok  = (eff_key == MASTER_KEY) || (eff_key == attr.key);
    allowed = key_ok || ((kind == ACC_FETCH) && !attr.fguard);
    grant   = req_valid && allowed;
    deny    = req_valid && !allowed;
    exc_frame = deny ? req_frame : '0;
  end
endmodule

// File: rtl/skey_guard.sv
module skey_guard
  import skey_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_frame,
  input  logic [3:0]       cfg_key,
  input  logic             cfg_fguard,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_frame,
  input  logic             req_store,
  input  logic [3:0]       psw_key,
  input  logic             ovr_valid,
  input  logic [3:0]       ovr_key,
  output logic             grant,
  output logic             deny,
  output logic [IDX_W-1:0] exc_frame
);
  frame_attr_t wr_attr;
  frame_attr_t rd_attr;
  skey_t       eff_key;

  assign wr_attr = '{key: cfg_key, fguard: cfg_fguard};

  skey_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_frame),
    .wr_attr (wr_attr),
    .rd_idx  (req_frame),
    .rd_attr (rd_attr)
  );

  skey_select u_select (
    .psw_key   (psw_key),
    .ovr_valid (ovr_valid),
    .ovr_key   (ovr_key),
    .eff_key   (eff_key)
  );

  skey_judge #(.IDX_W(IDX_W)) u_judge (
    .req_valid (req_valid),
    .req_store (req_store),
    .req_frame (req_frame),
    .eff_key   (eff_key),
    .attr      (rd_attr),
    .grant     (grant),
    .deny      (deny),
    .exc_frame (exc_frame)
  );
endmodule

// File: rtl/skey_guard_chk.sv
module skey_guard_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_frame,
  input logic [3:0]       cfg_key,
  input logic             cfg_fguard,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_frame,
  input logic             req_store,
  input logic [3:0]       psw_key,
  input logic             ovr_valid,
  input logic [3:0]       ovr_key,
  input logic             grant,
  input logic             deny,
  input logic [IDX_W-1:0] exc_frame
);
  localparam int DEPTH = 1 << IDX_W;

  logic [3:0] sh_key [DEPTH];
  logic       sh_fg  [DEPTH];
  logic       sh_live;
  logic [3:0] use_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_live <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        sh_key[i] <= '0;
        sh_fg[i]  <= 1'b0;
      end
    end else if (cfg_we) begin
      sh_key[cfg_frame] <= cfg_key;
      sh_fg[cfg_frame]  <= cfg_fguard;
    end
  end

  assign use_key = ovr_valid ? ovr_key : psw_key;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst) !(grant && deny)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !req_valid |-> (!grant && !deny)); // R8
  AST_MASTER_PASS: assert property (@(posedge clk) disable iff (rst) (req_valid && use_key == 4'd0) |-> grant); // R3
  AST_KEY_MATCH: assert property (@(posedge clk) disable iff (rst || !sh_live) (req_valid && use_key == sh_key[req_frame]) |-> grant); // R4
  AST_FETCH_OPEN: assert property (@(posedge clk) disable iff (rst || !sh_live) (req_valid && !req_store && !sh_fg[req_frame]) |-> grant); // R5
  AST_GUARD_BLOCK: assert property (@(posedge clk) disable iff (rst || !sh_live) (req_valid && use_key != 4'd0 && use_key != sh_key[req_frame] && sh_fg[req_frame]) |-> deny); // R6
  AST_EXC_INDEX: assert property (@(posedge clk) disable iff (rst) deny |-> (exc_frame == req_frame)); // R7
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (rst) !deny |-> (exc_frame == '0)); // R7
endmodule

bind skey_guard skey_guard_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
  .cfg_key(cfg_key), .cfg_fguard(cfg_fguard), .req_valid(req_valid),
  .req_frame(req_frame), .req_store(req_store), .psw_key(psw_key),
  .ovr_valid(ovr_valid), .ovr_key(ovr_key), .grant(grant), .deny(deny),
  .exc_frame(exc_frame)
);

// File: tb/skey_guard_test.sv
module skey_guard_test;
  localparam int FRAMES = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_fguard = 0, req_valid = 0, req_store = 0, ovr_valid = 0;
  logic [IW-1:0] cfg_frame = '0, req_frame = '0;
  logic [3:0] cfg_key = '0, psw_key = '0, ovr_key = '0;
  logic grant, deny;
  logic [IW-1:0] exc_frame;

  int checks = 0;
  int errors = 0;
  int mkey [FRAMES];
  bit mfg [FRAMES];
  string phase = "";

  always #5 clk = ~clk;

  skey_guard #(.FRAMES(FRAMES)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
    .cfg_key(cfg_key), .cfg_fguard(cfg_fguard), .req_valid(req_valid),
    .req_frame(req_frame), .req_store(req_store), .psw_key(psw_key),
    .ovr_valid(ovr_valid), .ovr_key(ovr_key), .grant(grant), .deny(deny),
    .exc_frame(exc_frame)
  );

  // Reference table: reset clears, write port updates at the edge (R1, R9)
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FRAMES; i++) begin mkey[i] = 0; mfg[i] = 0; end
    end else if (cfg_we) begin
      mkey[cfg_frame] = cfg_key;
      mfg[cfg_frame]  = cfg_fguard;
    end
  end

  task automatic check_now();
    int ak, fk;
    bit ok, eg, ed;
    int ef;
    string tag;
    ak = ovr_valid ? ovr_key : psw_key;
    fk = mkey[req_frame];
    ok = (ak == 0) || (ak == fk) || (!req_store && !mfg[req_frame]);
    eg = req_valid && ok;
    ed = req_valid && !ok;
    ef = ed ? req_frame : 0;
    if (!req_valid)      tag = "R8";
    else if (ak == 0)    tag = "R3";
    else if (ak == fk)   tag = "R4";
    else if (!mfg[req_frame]) tag = "R5";
    else                 tag = "R6";
    checks++;
    if (grant !== eg || deny !== ed) begin
      errors++;
      $display("FAIL %s/R10 [%s] grant,deny=%b%b expected %b%b", tag, phase, grant, deny, eg, ed);
    end
    checks++;
    if (exc_frame !== ef[IW-1:0]) begin
      errors++;
      $display("FAIL R7 [%s] exc_frame=%0d expected %0d", phase, exc_frame, ef);
    end
  endtask

  task automatic cyc(input bit v, input int f, input bit st, input int pk,
                     input bit ov, input int ok, input bit we, input int wf,
                     input int wk, input bit wg);
    @(negedge clk);
    req_valid = v; req_frame = f[IW-1:0]; req_store = st;
    psw_key = pk[3:0]; ovr_valid = ov; ovr_key = ok[3:0];
    cfg_we = we; cfg_frame = wf[IW-1:0]; cfg_key = wk[3:0]; cfg_fguard = wg;
    #2 check_now();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    phase = "R1 reset contents";
    for (int f = 0; f < FRAMES; f++) begin
      cyc(1, f, 0, 5, 0, 0, 0, 0, 0, 0);
      cyc(1, f, 1, 5, 0, 0, 0, 0, 0, 0);
    end

    phase = "R8 idle";
    cyc(0, 3, 1, 5, 0, 0, 0, 0, 0, 0);

    phase = "R3 R4 R5 R6 directed";
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 9, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 4, 9, 1);
    for (int s = 0; s < 2; s++) begin
      cyc(1, 3, s[0], 9, 0, 0, 0, 0, 0, 0);
      cyc(1, 4, s[0], 9, 0, 0, 0, 0, 0, 0);
      cyc(1, 3, s[0], 2, 0, 0, 0, 0, 0, 0);
      cyc(1, 4, s[0], 2, 0, 0, 0, 0, 0, 0);
      cyc(1, 4, s[0], 0, 0, 0, 0, 0, 0, 0);
    end

    phase = "R2 override ignored when invalid";
    for (int k = 0; k < 16; k++) cyc(1, 4, 1, 9, 0, k, 0, 0, 0, 0);
    phase = "R2 override used";
    cyc(1, 4, 1, 9, 1, 2, 0, 0, 0, 0);
    cyc(1, 4, 0, 9, 1, 2, 0, 0, 0, 0);
    cyc(1, 4, 1, 2, 1, 9, 0, 0, 0, 0);
    cyc(1, 4, 1, 2, 1, 0, 0, 0, 0, 0);

    phase = "R9 same-cycle write";
    cyc(1, 5, 1, 7, 0, 0, 1, 5, 7, 1);
    cyc(1, 5, 1, 7, 0, 0, 0, 0, 0, 0);
    cyc(1, 5, 0, 3, 0, 0, 1, 5, 3, 0);
    cyc(1, 5, 0, 3, 0, 0, 0, 0, 0, 0);

    phase = "R10 random mix";
    for (int n = 0; n < 4000; n++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
          $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 15),
          $urandom_range(0, 3) == 0, $urandom_range(0, 7), $urandom_range(0, 15),
          $urandom_range(0, 1));
    end

    phase = "R1 reset again";
    @(negedge clk) begin rst = 1'b1; cfg_we = 0; req_valid = 0; end
    @(negedge clk) rst = 1'b0;
    cyc(1, 4, 0, 9, 0, 0, 0, 0, 0, 0);
    cyc(1, 4, 1, 9, 0, 0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule